// File: doc/BRIEF.md
# Indirect Memory Access Port

This block gives a byte-wide host a way into three internal memories that are not mapped into the host's address space: a data memory of one byte per location and a connection memory of two bytes (low and high) per location. The host first loads an address register, then a mode register that picks the memory space and sets the auto-increment options. Each later access to the data register reads or writes the selected location, and the address and space selection then step on their own. The host can stream bytes through the data register without reloading the address for every byte.

Connection-memory accesses alternate between the low and the high byte of one location. The address moves on only after the high byte. The memories are plain arrays inside the block and are cleared by reset. Reads of any register are combinational on the register select. Side effects of an access (stores, address and space stepping) take place at the rising clock edge while the strobe is high.

Top module: `ind_mem_port`

## Requirements
- R1: After reset the address is 0, the space is data memory (code 0) and both auto-increment enables are off, so register 0 and register 1 both read 0x00 and all memory locations read 0x00.
- R2: Register select 0 holds address bits [7:0]. Register select 1 is the mode byte: bits [1:0] give the space (0 data, 1 connection low byte, 2 connection high byte, 3 reserved), bit 2 gives address bit 8, bit 6 enables increment after reads and bit 7 enables increment after writes. Both registers read back what the host loaded, and the space field shows the current selection.
- R3: A write to register select 2 stores the byte at the current address in the selected space, and a read of register select 2 returns the byte stored there.
- R4: In data space the address advances by one after a write only when bit 7 is set, and after a read only when bit 6 is set. A read never advances while only bit 7 is set.
- R5: With the enable for the current direction set and a connection space selected, accesses alternate low byte, high byte of the same location, then the low byte of the next location. The address advances only on the high-byte access. After address 0 is loaded and the mode is 0x81, the first written byte lands in the low byte of location 0 and the second in its high byte.
- R6: With the enable for the current direction clear, an access in connection low-byte space switches the selection to the high byte once. Further accesses stay on the high byte, and the address does not change.
- R7: An address advance from 383 or above gives address 0.
- R8: At addresses 384 to 511, writes change no memory and reads return 0x00. Sequencing still applies.
- R9: With the reserved space selected, data-register writes are ignored, reads return 0x00, and neither the address nor the space changes.
- R10: When the read and write strobes are high together, only the write takes effect.
- R11: Register select 3 reads 0x00, and a write to it changes no register or memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 address, 1 mode, 2 data, 3 unused |
| wr_stb | input | 1 | Write strobe, acts at the clock edge |
| rd_stb | input | 1 | Read strobe, its side effects act at the clock edge |
| wr_data | input | 8 | Byte written by the host |
| rd_data | output | 8 | Byte read from the selected register, combinational |

## Verification
If the sequencer holds a wrong address or space, the error shows up on the next data-register read. That read returns a byte from the wrong location or byte lane, or reads back the mode register with a wrong space field. The bench mirrors every access in a model of the three memories and compares every read, so a stepping error shows within the few accesses that follow. Because the memories keep their contents, a misplaced write stays visible and is caught whenever any later read lands on that location.

// File: rtl/ind_port_pkg.sv
package ind_port_pkg;

   typedef enum logic [1:0] {
      SPC_DATA = 2'd0,
      SPC_CML  = 2'd1,
      SPC_CMH  = 2'd2,
      SPC_RSVD = 2'd3
   } space_e;

   typedef enum logic [1:0] {
      RS_ADDR = 2'd0,
      RS_MODE = 2'd1,
      RS_DATA = 2'd2,
      RS_NONE = 2'd3
   } regsel_e;

   localparam int MODE_SPC_LSB  = 0;
   localparam int MODE_AHI_LSB  = 2;
   localparam int MODE_INCR_BIT = 6;
   localparam int MODE_INCW_BIT = 7;

endpackage

// File: rtl/ind_bank.sv
module ind_bank #(
   parameter int AW    = 9,
   parameter int DEPTH = 384,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam bit FULL = (DEPTH == (1 << AW));

   logic [DW-1:0] mem [DEPTH];
   logic          in_range;

   generate
      if (DEPTH > (1 << AW) || DEPTH < 2) begin : g_bad_depth
         $error("ind_bank: DEPTH must lie in 2 .. 2**AW");
      end
      if (FULL) begin : g_full
         assign in_range = 1'b1;
      end else begin : g_partial
         assign in_range = (int'(addr) < DEPTH);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && in_range) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = in_range ? mem[addr] : '0;

   AST_BANK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && in_range) |=> (mem[$past(addr)] == $past(wdata))); // R3

endmodule

// File: rtl/ind_seq.sv
module ind_seq
   import ind_port_pkg::*;
#(
   parameter int AW    = 9,
   parameter int DEPTH = 384
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_addr,
   input  logic          ld_mode,
   input  logic [7:0]    wdata,
   input  logic          acc_wr,
   input  logic          acc_rd,
   output logic [AW-1:0] addr,
   output space_e        space,
   output logic          inc_rd,
   output logic          inc_wr
);
   localparam int HI_W = AW - 8;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (HI_W < 1 || HI_W > 3) begin : g_bad_aw
         $error("ind_seq: AW must lie in 9 .. 11");
      end
   endgenerate

   logic          acc;
   logic          inc_on;
   logic [AW-1:0] addr_nxt;

   assign acc      = acc_wr | acc_rd;
   assign inc_on   = acc_wr ? inc_wr : inc_rd;
   assign addr_nxt = (addr >= LAST) ? '0 : addr + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr   <= '0;
         space  <= SPC_DATA;
         inc_rd <= 1'b0;
         inc_wr <= 1'b0;
      end else if (ld_addr) begin
         addr[7:0] <= wdata;
      end else if (ld_mode) begin
         space        <= space_e'(wdata[MODE_SPC_LSB +: 2]);
         addr[AW-1:8] <= wdata[MODE_AHI_LSB +: HI_W];
         inc_rd       <= wdata[MODE_INCR_BIT];
         inc_wr       <= wdata[MODE_INCW_BIT];
      end else if (acc) begin
         unique case (space)
            SPC_DATA: if (inc_on) addr <= addr_nxt;
            SPC_CML:  space <= SPC_CMH;
            SPC_CMH:  if (inc_on) begin
                         space <= SPC_CML;
                         addr  <= addr_nxt;
                      end
            default:  ;
         endcase
      end
   end

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ld_addr && !ld_mode && inc_on && (space == SPC_DATA || space == SPC_CMH)
       && addr >= LAST) |=> (addr == '0)); // R7
   AST_LOW_TO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ld_addr && !ld_mode && space == SPC_CML) |=> (space == SPC_CMH && $stable(addr))); // R6
   AST_HIGH_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ld_addr && !ld_mode && inc_on && space == SPC_CMH) |=> (space == SPC_CML)); // R5
   AST_NO_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ld_addr && !ld_mode && !inc_on) |=> $stable(addr)); // R4
   AST_RD_IGNORES_WINC: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && !acc_wr && !ld_addr && !ld_mode && inc_wr && !inc_rd) |=> $stable(addr)); // R4
   AST_RSVD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ld_addr && !ld_mode && space == SPC_RSVD) |=> ($stable(addr) && space == SPC_RSVD)); // R9

endmodule

// File: rtl/ind_mem_port.sv
module ind_mem_port
   import ind_port_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter int MEM_DEPTH = 384,
   parameter int CM_LANES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_sel,
   input  logic       wr_stb,
   input  logic       rd_stb,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data
);
   localparam int HI_W = ADDR_W - 8;

   generate
      if (CM_LANES != 2) begin : g_bad_lanes
         $error("ind_mem_port: the space code supports exactly two connection lanes");
      end
   endgenerate

   regsel_e           sel;
   logic              ld_addr, ld_mode, acc_wr, acc_rd;
   logic [ADDR_W-1:0] addr;
   space_e            space;
   logic              inc_rd, inc_wr;
   logic [7:0]        dm_rdata;
   logic [7:0]        cm_rdata [CM_LANES];
   logic [7:0]        mode_rb;
   logic [7:0]        data_rb;

   assign sel     = regsel_e'(reg_sel);
   assign ld_addr = wr_stb && sel == RS_ADDR;
   assign ld_mode = wr_stb && sel == RS_MODE;
   assign acc_wr  = wr_stb && sel == RS_DATA;
   assign acc_rd  = rd_stb && !wr_stb && sel == RS_DATA;

   ind_seq #(.AW(ADDR_W), .DEPTH(MEM_DEPTH)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_addr (ld_addr),
      .ld_mode (ld_mode),
      .wdata   (wr_data),
      .acc_wr  (acc_wr),
      .acc_rd  (acc_rd),
      .addr    (addr),
      .space   (space),
      .inc_rd  (inc_rd),
      .inc_wr  (inc_wr)
   );

   ind_bank #(.AW(ADDR_W), .DEPTH(MEM_DEPTH), .DW(8)) i_dmem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (acc_wr && space == SPC_DATA),
      .addr  (addr),
      .wdata (wr_data),
      .rdata (dm_rdata)
   );

   generate
      for (genvar g = 0; g < CM_LANES; g++) begin : g_cm_lane
         ind_bank #(.AW(ADDR_W), .DEPTH(MEM_DEPTH), .DW(8)) i_cmem (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (acc_wr && space == space_e'(g + 1)),
            .addr  (addr),
            .wdata (wr_data),
            .rdata (cm_rdata[g])
         );
      end
   endgenerate

   always_comb begin
      mode_rb = '0;
      mode_rb[MODE_SPC_LSB +: 2]    = space;
      mode_rb[MODE_AHI_LSB +: HI_W] = addr[ADDR_W-1:8];
      mode_rb[MODE_INCR_BIT]        = inc_rd;
      mode_rb[MODE_INCW_BIT]        = inc_wr;
   end

   always_comb begin
      unique case (space)
         SPC_DATA: data_rb = dm_rdata;
         SPC_CML:  data_rb = cm_rdata[0];
         SPC_CMH:  data_rb = cm_rdata[1];
         default:  data_rb = '0;
      endcase
   end

   always_comb begin
      unique case (sel)
         RS_ADDR: rd_data = addr[7:0];
         RS_MODE: rd_data = mode_rb;
         RS_DATA: rd_data = data_rb;
         default: rd_data = '0;
      endcase
   end

   AST_DUAL_STROBE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && rd_stb && sel == RS_DATA && space == SPC_DATA && !inc_wr)
      |=> $stable(addr)); // R10

endmodule

// File: tb/test_ind_mem_port.sv
`timescale 1ns/1ps
module test_ind_mem_port;
   localparam int DEPTH = 384;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = '0;
   logic       wr_stb = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_addr, m_space;
   bit m_incr, m_incw;
   byte unsigned m_dm [512];
   byte unsigned m_lo [512];
   byte unsigned m_hi [512];

   always #2.5 clk = ~clk;

   ind_mem_port i_ind_mem_port (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_stb(wr_stb),
      .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data)
   );

   function automatic byte unsigned exp_read(int sel);
      byte unsigned v;
      v = 0;
      case (sel)
         0: v = byte'(m_addr & 8'hFF);
         1: v = byte'({m_incw, m_incr, 3'b000, m_addr[8], m_space[1:0]});
         2: if (m_addr < DEPTH) begin
               case (m_space)
                  0: v = m_dm[m_addr];
                  1: v = m_lo[m_addr];
                  2: v = m_hi[m_addr];
                  default: v = 0;
               endcase
            end
         default: v = 0;
      endcase
      return v;
   endfunction

   function automatic int next_addr(int a);
      return (a >= DEPTH - 1) ? 0 : a + 1;
   endfunction

   function automatic void model_step(bit is_wr);
      bit inc;
      inc = is_wr ? m_incw : m_incr;
      case (m_space)
         0: if (inc) m_addr = next_addr(m_addr);
         1: m_space = 2;
         2: if (inc) begin m_space = 1; m_addr = next_addr(m_addr); end
         default: ;
      endcase
   endfunction

   function automatic void model_apply(int sel, bit wr, bit rd, byte unsigned d);
      if (wr) begin
         case (sel)
            0: m_addr = (m_addr & 32'h100) | int'(d);
            1: begin
                  m_space = int'(d[1:0]);
                  m_addr  = (m_addr & 32'hFF) | (int'(d[2]) << 8);
                  m_incr  = d[6];
                  m_incw  = d[7];
               end
            2: begin
                  if (m_addr < DEPTH) begin
                     case (m_space)
                        0: m_dm[m_addr] = d;
                        1: m_lo[m_addr] = d;
                        2: m_hi[m_addr] = d;
                        default: ;
                     endcase
                  end
                  model_step(1'b1);
               end
            default: ;
         endcase
      end else if (rd && sel == 2) begin
         model_step(1'b0);
      end
   endfunction

   task automatic check(string tag, byte unsigned act, byte unsigned exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic do_op(string tag, int sel, bit wr, bit rd, byte unsigned d);
      @(negedge clk);
      reg_sel = 2'(sel);
      wr_stb  = wr;
      rd_stb  = rd;
      wr_data = d;
      #1;
      if (rd && !wr) check(tag, rd_data, exp_read(sel));
      @(posedge clk);
      #1;
      wr_stb = 1'b0;
      rd_stb = 1'b0;
      model_apply(sel, wr, rd, d);
   endtask

   task automatic wr_reg(int sel, byte unsigned d);
      do_op("WR", sel, 1'b1, 1'b0, d);
   endtask

   task automatic rd_reg(string tag, int sel);
      do_op(tag, sel, 1'b0, 1'b1, 8'h00);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      m_addr = 0; m_space = 0; m_incr = 0; m_incw = 0;
      for (int i = 0; i < 512; i++) begin m_dm[i] = 0; m_lo[i] = 0; m_hi[i] = 0; end
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd_reg("R1 addr", 0);
      rd_reg("R1 mode", 1);
      rd_reg("R1 mem", 2);

      // R2 register map readback
      wr_reg(0, 8'h5A);
      wr_reg(1, 8'hC6);
      rd_reg("R2 addr", 0);
      rd_reg("R2 mode", 1);

      // R3 data memory store and fetch
      wr_reg(0, 8'h10); wr_reg(1, 8'h00);
      wr_reg(2, 8'h3C);
      rd_reg("R3 data", 2);

      // R4 independent increments
      wr_reg(0, 8'h20); wr_reg(1, 8'h80);
      wr_reg(2, 8'hA1); wr_reg(2, 8'hA2);
      rd_reg("R4 addr after winc", 0);
      rd_reg("R4 read no winc", 2);
      rd_reg("R4 read no winc", 2);
      rd_reg("R4 addr held", 0);
      wr_reg(0, 8'h20); wr_reg(1, 8'h40);
      rd_reg("R4 rinc a", 2);
      rd_reg("R4 rinc b", 2);
      rd_reg("R4 addr after rinc", 0);

      // R5 connection fill from location 0
      wr_reg(0, 8'h00); wr_reg(1, 8'h81);
      wr_reg(2, 8'hAA); wr_reg(2, 8'hBB); wr_reg(2, 8'hCC); wr_reg(2, 8'hDD);
      rd_reg("R5 addr", 0);
      wr_reg(0, 8'h00); wr_reg(1, 8'h02);
      rd_reg("R5 hi0", 2);
      wr_reg(1, 8'h01);
      rd_reg("R5 lo0", 2);
      wr_reg(0, 8'h00); wr_reg(1, 8'h41);
      rd_reg("R5 seq lo0", 2); rd_reg("R5 seq hi0", 2);
      rd_reg("R5 seq lo1", 2); rd_reg("R5 seq hi1", 2);
      rd_reg("R5 mode", 1);

      // R6 toggle once without increment
      wr_reg(0, 8'h07); wr_reg(1, 8'h01);
      wr_reg(2, 8'h11); wr_reg(2, 8'h22); wr_reg(2, 8'h33);
      rd_reg("R6 mode", 1);
      rd_reg("R6 addr", 0);
      rd_reg("R6 hi", 2);
      wr_reg(1, 8'h01);
      rd_reg("R6 lo", 2);

      // R7 wrap from 383
      wr_reg(0, 8'h7F); wr_reg(1, 8'h84);
      wr_reg(2, 8'h99);
      rd_reg("R7 addr", 0);
      rd_reg("R7 mode", 1);
      wr_reg(0, 8'hF0); wr_reg(1, 8'h86);
      wr_reg(2, 8'h01); wr_reg(2, 8'h02);
      rd_reg("R7 addr cm", 0);

      // R8 out of range
      wr_reg(0, 8'h90); wr_reg(1, 8'h04);
      wr_reg(2, 8'hEE);
      rd_reg("R8 read", 2);
      wr_reg(0, 8'h10); wr_reg(1, 8'h00);
      rd_reg("R8 alias", 2);

      // R9 reserved space
      wr_reg(0, 8'h10); wr_reg(1, 8'hC3);
      wr_reg(2, 8'h77);
      rd_reg("R9 read", 2);
      rd_reg("R9 mode", 1);
      rd_reg("R9 addr", 0);
      wr_reg(1, 8'h00);
      rd_reg("R9 dm", 2);

      // R10 both strobes
      wr_reg(0, 8'h30); wr_reg(1, 8'h40);
      do_op("WR", 2, 1'b1, 1'b1, 8'h5E);
      rd_reg("R10 addr", 0);
      rd_reg("R10 data", 2);

      // R11 unused select
      wr_reg(3, 8'hFF);
      rd_reg("R11 read", 3);
      rd_reg("R11 addr", 0);
      rd_reg("R11 mode", 1);

      // random mix (R3 R4 R5 R6 R7 R8)
      for (int n = 0; n < 4000; n++) begin
         int r, sel;
         byte unsigned d;
         r = int'($urandom_range(0, 99));
         d = byte'($urandom);
         if (r < 8) begin
            int a;
            a = ($urandom_range(0, 9) == 0) ? int'($urandom_range(376, 511))
                                            : int'($urandom_range(0, 383));
            wr_reg(0, byte'(a & 8'hFF));
            d[2] = a[8];
            d[1:0] = ($urandom_range(0, 19) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            wr_reg(1, d);
         end else if (r < 12) begin
            sel = int'($urandom_range(0, 1));
            rd_reg("RND R2", sel);
         end else begin
            sel = 2;
            if ($urandom_range(0, 1) == 1) wr_reg(sel, d);
            else rd_reg("RND R3", sel);
         end
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule